// File: doc/BRIEF.md
# ADC Input Configuration Controller with Filter Settling Guard

This block is the digital control logic for the input side of an oversampling converter. A host writes an input-channel code, a gain code and an input-buffer mode through a simple write port. The buffer mode goes to the analog side at once. The channel and gain codes are held in shadow registers. They reach the analog multiplexer and the amplifier only when the digital filter reports a decimation step, so a selection never changes in the middle of a decimation interval.

The block also tracks how far the decimation filter has settled. A start pulse or an applied channel/gain change restarts a settling count. Each conversion-complete strobe advances the count, and the count saturates. The results of the first three conversions after a restart come from a filter that has not yet settled, so the interrupt request is held off for them. From the fourth conversion on, every conversion-complete produces a one-cycle interrupt request.

A decoded channel-class output tells the analog side whether the active code selects an external pair, the internal supply divider, the temperature sensor or the shorted pair used for offset calibration.

Top module: `adcCfgCtrl`

## Requirements
- R1: After reset, muxSel, gainSel, bufMode and chanKind are 0 and irqReq is low. The settling count is in its "not settled" state, so the first three conversions after reset raise no interrupt.
- R2: chanKind decodes the active channel code as follows: codes 0 to 4 give 0 (external pair), code 5 gives 1 (supply divider), code 6 gives 2 (temperature sensor) and code 7 gives 3 (shorted pair).
- R3: A write (cfgWrEn high) without decimStep in the same cycle leaves muxSel and gainSel unchanged. On the first later cycle with decimStep high, the most recently written channel and gain appear on muxSel and gainSel, one clock after that strobe.
- R4: When cfgWrEn and decimStep are high in the same cycle, the values written in that cycle are applied at that strobe.
- R5: A decimStep with no write pending leaves muxSel and gainSel unchanged and does not restart the settling count.
- R6: Gain codes 6 and 7 are unused and are applied as gain code 5, so gainSel never exceeds 5.
- R7: bufMode takes the written buffer-mode field one clock after any write, whether or not a decimation step occurs.
- R8: After a start pulse, the first three conversion-done strobes raise no interrupt. The fourth and every later one each raise irqReq for exactly the clock cycle after the strobe.
- R9: Applying a pending or same-cycle channel/gain write at a decimation step restarts the settling count in the same way a start pulse does.
- R10: A conversion-done strobe that arrives in the same cycle as a start pulse or an applied configuration change raises no interrupt and is not counted toward settling.
- R11: irqReq is high only in a cycle that directly follows a conversion-done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgChan | input | 3 | Written channel code |
| cfgGain | input | 3 | Written gain code |
| cfgBuf | input | 2 | Written buffer mode: 0 off, 1 low, 2 medium, 3 high speed/current |
| decimStep | input | 1 | Decimation-step strobe from the filter |
| convDone | input | 1 | Conversion-complete strobe |
| startPulse | input | 1 | Start-of-conversion pulse |
| muxSel | output | 3 | Active channel code to the analog multiplexer |
| gainSel | output | 3 | Active gain code to the amplifier |
| bufMode | output | 2 | Buffer mode to the analog side |
| chanKind | output | 2 | Class of the active channel |
| irqReq | output | 1 | Conversion interrupt request, one-cycle pulse |

## Verification
A lost or stuck pending flag shows at the ports on the first decimation step after a write: the multiplexer or gain output either fails to move or moves when it should not. A wrong settling count shows as an interrupt that is present or missing in the cycle after the first few conversion-done strobes following a start or an applied change, so the error appears within four conversions. The bench runs a behavioural reference model on every clock, in directed sequences and in a long random phase, so any difference is reported in the cycle where it first appears.

// File: rtl/adcCfgPkg.sv
package adcCfgPkg;
  localparam int CHAN_W = 3;
  localparam int GAIN_W = 3;
  localparam int BUF_W  = 2;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_EXT    = 2'd0,
    KIND_SUPPLY = 2'd1,
    KIND_TEMP   = 2'd2,
    KIND_SHORT  = 2'd3
  } chanKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadShadow;   // capture write into shadow, hold active
    logic applyShadow;  // copy shadow to active
    logic applyDirect;  // write and step together: load active from port
  } cfgStrobe_t;
endpackage

// File: rtl/adcSettleCtrl.sv
module adcSettleCtrl
  import adcCfgPkg::*;
#(
  parameter int SETTLE_CONV = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       decimStep,
  input  logic       convDone,
  input  logic       startPulse,
  output cfgStrobe_t strobe,
  output logic       irqReq
);
  localparam int CNT_W = $clog2(SETTLE_CONV + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SETTLE_CONV);

  logic             pending;
  logic [CNT_W-1:0] settleCnt;
  logic             restart;
  logic             settled;

  always_comb begin
    strobe.applyDirect = cfgWrEn && decimStep;
    strobe.applyShadow = decimStep && pending && !cfgWrEn;
    strobe.loadShadow  = cfgWrEn && !decimStep;
  end

  assign restart = startPulse || strobe.applyDirect || strobe.applyShadow;
  assign settled = (settleCnt == CNT_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (decimStep) begin
      pending <= 1'b0;
    end else if (cfgWrEn) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (restart) begin
      settleCnt <= '0;
    end else if (convDone && !settled) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
    end else begin
      irqReq <= convDone && settled && !restart;
    end
  end
endmodule

// File: rtl/adcCfgPath.sv
module adcCfgPath
  import adcCfgPkg::*;
#(
  parameter int GAIN_MAX    = 5,
  parameter int SUPPLY_CODE = 5,
  parameter int TEMP_CODE   = 6,
  parameter int SHORT_CODE  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic              cfgWrEn,
  input  logic [CHAN_W-1:0] wrChan,
  input  logic [GAIN_W-1:0] wrGain,
  input  logic [BUF_W-1:0]  wrBuf,
  output logic [CHAN_W-1:0] muxSel,
  output logic [GAIN_W-1:0] gainSel,
  output logic [BUF_W-1:0]  bufMode,
  output logic [KIND_W-1:0] chanKind
);
  localparam logic [GAIN_W-1:0] GAIN_TOP  = GAIN_W'(GAIN_MAX);
  localparam logic [CHAN_W-1:0] SUPPLY_CH = CHAN_W'(SUPPLY_CODE);
  localparam logic [CHAN_W-1:0] TEMP_CH   = CHAN_W'(TEMP_CODE);
  localparam logic [CHAN_W-1:0] SHORT_CH  = CHAN_W'(SHORT_CODE);

  logic [CHAN_W-1:0] shadowChan;
  logic [GAIN_W-1:0] shadowGain;
  logic [GAIN_W-1:0] gainLegal;
  chanKind_e         kindNow;

  // unused gain encodings fold onto the top legal setting
  assign gainLegal = (wrGain > GAIN_TOP) ? GAIN_TOP : wrGain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowChan <= '0;
      shadowGain <= '0;
    end else if (strobe.loadShadow) begin
      shadowChan <= wrChan;
      shadowGain <= gainLegal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muxSel  <= '0;
      gainSel <= '0;
    end else if (strobe.applyDirect) begin
      muxSel  <= wrChan;
      gainSel <= gainLegal;
    end else if (strobe.applyShadow) begin
      muxSel  <= shadowChan;
      gainSel <= shadowGain;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufMode <= '0;
    end else if (cfgWrEn) begin
      bufMode <= wrBuf;
    end
  end

  always_comb begin
    if (muxSel == SHORT_CH)       kindNow = KIND_SHORT;
    else if (muxSel == TEMP_CH)   kindNow = KIND_TEMP;
    else if (muxSel == SUPPLY_CH) kindNow = KIND_SUPPLY;
    else                          kindNow = KIND_EXT;
  end

  assign chanKind = kindNow;
endmodule

// File: rtl/adcCfgCtrl.sv
module adcCfgCtrl
  import adcCfgPkg::*;
#(
  parameter int SETTLE_CONV = 3,
  parameter int GAIN_MAX    = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [2:0] cfgChan,
  input  logic [2:0] cfgGain,
  input  logic [1:0] cfgBuf,
  input  logic       decimStep,
  input  logic       convDone,
  input  logic       startPulse,
  output logic [2:0] muxSel,
  output logic [2:0] gainSel,
  output logic [1:0] bufMode,
  output logic [1:0] chanKind,
  output logic       irqReq
);
  cfgStrobe_t strobe;

  adcSettleCtrl #(.SETTLE_CONV(SETTLE_CONV)) ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .decimStep(decimStep),
    .convDone(convDone), .startPulse(startPulse),
    .strobe(strobe), .irqReq(irqReq)
  );

  adcCfgPath #(.GAIN_MAX(GAIN_MAX)) path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrEn(cfgWrEn),
    .wrChan(cfgChan), .wrGain(cfgGain), .wrBuf(cfgBuf),
    .muxSel(muxSel), .gainSel(gainSel), .bufMode(bufMode),
    .chanKind(chanKind)
  );
endmodule

// File: rtl/adcCfgCtrl_chk.sv
module adcCfgCtrl_chk #(
  parameter int GAIN_MAX = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic [1:0] cfgBuf,
  input logic       decimStep,
  input logic       convDone,
  input logic       startPulse,
  input logic [2:0] muxSel,
  input logic [2:0] gainSel,
  input logic [1:0] bufMode,
  input logic [1:0] chanKind,
  input logic       irqReq
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r6_gain_legal: assert property (@(posedge clk) disable iff (!rstN)
    int'(gainSel) <= GAIN_MAX);

  a_r3_hold_without_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(decimStep)) |-> ($stable(muxSel) && $stable(gainSel)));

  a_r7_buf_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(cfgWrEn)) |-> (bufMode == $past(cfgBuf)));

  a_r11_irq_after_done: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pastValid && $past(convDone)));

  a_r8_no_irq_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(startPulse)) |-> !irqReq);

  a_r2_short_pair_kind: assert property (@(posedge clk) disable iff (!rstN)
    (muxSel == 3'd7) |-> (chanKind == 2'd3));
endmodule

bind adcCfgCtrl adcCfgCtrl_chk #(.GAIN_MAX(GAIN_MAX)) chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgBuf(cfgBuf),
  .decimStep(decimStep), .convDone(convDone), .startPulse(startPulse),
  .muxSel(muxSel), .gainSel(gainSel), .bufMode(bufMode),
  .chanKind(chanKind), .irqReq(irqReq)
);

// File: tb/adcCfgCtrl_test.sv
`timescale 1ns/1ps
module adcCfgCtrl_test;
  localparam int SETTLE = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgChan = '0;
  logic [2:0] cfgGain = '0;
  logic [1:0] cfgBuf = '0;
  logic decimStep = 1'b0, convDone = 1'b0, startPulse = 1'b0;
  logic [2:0] muxSel, gainSel;
  logic [1:0] bufMode, chanKind;
  logic irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  int irqSeen = 0;
  bit finished = 1'b0;

  // reference model state
  int mMux, mGain, mBuf, mIrq, sMux, sGain, cnt;
  bit pend;

  always #4 clk = ~clk;

  adcCfgCtrl uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgChan(cfgChan),
    .cfgGain(cfgGain), .cfgBuf(cfgBuf), .decimStep(decimStep),
    .convDone(convDone), .startPulse(startPulse), .muxSel(muxSel),
    .gainSel(gainSel), .bufMode(bufMode), .chanKind(chanKind),
    .irqReq(irqReq)
  );

  function automatic int kindOf(int ch);
    if (ch == 7) return 3;
    if (ch == 6) return 2;
    if (ch == 5) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMux = 0; mGain = 0; mBuf = 0; mIrq = 0; sMux = 0; sGain = 0;
      cnt = 0; pend = 0;
    end else begin
      int g;
      bit restart;
      g = (int'(cfgGain) > 5) ? 5 : int'(cfgGain);
      restart = startPulse || (decimStep && (pend || cfgWrEn));
      mIrq = (convDone && cnt >= SETTLE && !restart) ? 1 : 0;
      if (restart) cnt = 0;
      else if (convDone && cnt < SETTLE) cnt++;
      if (decimStep && cfgWrEn) begin
        mMux = int'(cfgChan); mGain = g; pend = 0;
      end else if (decimStep) begin
        if (pend) begin mMux = sMux; mGain = sGain; end
        pend = 0;
      end else if (cfgWrEn) begin
        sMux = int'(cfgChan); sGain = g; pend = 1;
      end
      if (cfgWrEn) mBuf = int'(cfgBuf);
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(int'(muxSel) == mMux, "R3 muxSel", int'(muxSel), mMux);
      check(int'(gainSel) == mGain, "R6 gainSel", int'(gainSel), mGain);
      check(int'(bufMode) == mBuf, "R7 bufMode", int'(bufMode), mBuf);
      check(int'(chanKind) == kindOf(mMux), "R2 chanKind", int'(chanKind), kindOf(mMux));
      check(int'(irqReq) == mIrq, "R8 irqReq", int'(irqReq), mIrq);
      if (irqReq) irqSeen++;
    end
  end

  task automatic cyc(bit wr, int ch, int g, int b, bit dec, bit cd, bit st);
    cfgWrEn = wr; cfgChan = 3'(ch); cfgGain = 3'(g); cfgBuf = 2'(b);
    decimStep = dec; convDone = cd; startPulse = st;
    @(negedge clk);
    cfgWrEn = 0; decimStep = 0; convDone = 0; startPulse = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic convs(int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 0, 0, 1, 0);
      idle(1);
    end
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(muxSel == 0 && gainSel == 0 && bufMode == 0 && chanKind == 0 && !irqReq,
          "R1 reset outputs", int'(muxSel), 0);
    base = irqSeen;
    convs(3);
    check(irqSeen == base, "R1 no irq before settling", irqSeen - base, 0);

    // R8 start then five conversions: fourth and fifth interrupt
    cyc(0, 0, 0, 0, 0, 0, 1);
    base = irqSeen;
    convs(3);
    check(irqSeen == base, "R8 first three silent", irqSeen - base, 0);
    convs(2);
    check(irqSeen == base + 2, "R8 fourth and fifth fire", irqSeen - base, 2);

    // R3 write held until decimation step
    cyc(1, 5, 2, 1, 0, 0, 0);
    idle(3);
    check(muxSel == 0 && gainSel == 0, "R3 held before step", int'(muxSel), 0);
    check(bufMode == 1, "R7 buffer immediate", int'(bufMode), 1);
    cyc(1, 6, 3, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    check(muxSel == 6 && gainSel == 3, "R3 latest write applied", int'(muxSel), 6);
    check(chanKind == 2, "R2 temperature class", int'(chanKind), 2);

    // R4 and R6 same-cycle write and step with unused gain code
    cyc(1, 7, 7, 3, 1, 0, 0);
    check(muxSel == 7 && gainSel == 5, "R4 direct apply gain", int'(gainSel), 5);
    check(chanKind == 3, "R2 shorted class", int'(chanKind), 3);

    // R9 applied change restarts settling
    base = irqSeen;
    convs(3);
    check(irqSeen == base, "R9 silent after change", irqSeen - base, 0);
    convs(1);
    check(irqSeen == base + 1, "R9 fires on fourth", irqSeen - base, 1);

    // R5 step without pending write changes nothing
    cyc(0, 0, 0, 0, 1, 0, 0);
    check(muxSel == 7 && gainSel == 5, "R5 outputs kept", int'(muxSel), 7);
    base = irqSeen;
    convs(1);
    check(irqSeen == base + 1, "R5 no restart", irqSeen - base, 1);

    // R10 conversion coinciding with start is neither signalled nor counted
    base = irqSeen;
    cyc(0, 0, 0, 0, 0, 1, 1);
    idle(1);
    convs(3);
    check(irqSeen == base, "R10 coincident start", irqSeen - base, 0);
    convs(1);
    check(irqSeen == base + 1, "R10 fourth after start", irqSeen - base, 1);

    // R11 random phase checked by model every clock
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 5) == 0, $urandom_range(0, 7), $urandom_range(0, 7),
          $urandom_range(0, 3), $urandom_range(0, 3) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, 30) == 0);
    end
    idle(2);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule